// File: doc/BRIEF.md
# Simultaneous-Sampling Converter Result Sequencer

This block is the digital control model of a four-channel, 14-bit simultaneous-sampling converter that runs from an external converter clock. A host pulses an active-low convert-start line: its falling edge arms a request and its rising edge starts the conversion. At that rising edge the block captures all channel sample words from its input ports. It then counts converter clocks and reports each channel result as it becomes ready with a one-clock active-low end-of-conversion pulse. When the final result is ready, an active-low last-result flag also falls.

Results are read over a parallel bus. The bus is modelled as a data word plus an output enable, and it is driven only while both the active-low select and the active-low read strobe are low. Each completed read step moves the channel pointer to the next result. A convert-start request that arrives while a conversion runs, or inside the short quiet window after the last result, is ignored.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A conversion starts at the first clock edge that sees `cnv_n` high after an accepted falling edge of `cnv_n`. Counting that edge as edge 0, the block captures all of `smp_data` at it and ignores later changes of `smp_data` until the next start.
- R2: After edge 0, `eoc_n` is low in the cycle following edge 17 and high in the cycle following edge 16.
- R3: Results become ready after edges 17, 20, 23 and 26, and `eoc_n` pulses low after each of these edges. They are read in channel order 0, 1, 2, 3, and channel i is `smp_data[i*14 +: 14]`.
- R4: Each `eoc_n` low pulse lasts exactly one clock.
- R5: `eolc_n` falls in the same cycle as the fourth `eoc_n` pulse (after edge 26). It stays low until an accepted falling edge of `cnv_n`.
- R6: `bus_oe` is 1 and `bus_q` carries the current result only while `cs_n` and `rd_n` are both low. Otherwise `bus_oe` is 0 and `bus_q` is zero.
- R7: When the select-and-read condition ends, the pointer advances by one channel at the next clock edge. Reads beyond the fourth result return channel 3 again.
- R8: Holding `cs_n` low for the whole sequence gives the same read results as driving `cs_n` together with `rd_n`.
- R9: A falling edge of `cnv_n` sampled at edges 1 to 28 after a start is ignored, so it changes neither the schedule, the captured samples nor `eolc_n`. A falling edge sampled at edge 29 or later is accepted.
- R10: Every new start resets the read pointer to channel 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv_n | input | 1 | Active-low convert-start request |
| smp_data | input | 56 | Four packed sample words, channel i at bits i*14 +: 14 |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| eoc_n | output | 1 | One-clock low pulse per ready result |
| eolc_n | output | 1 | Low once the last result is ready |
| bus_q | output | 14 | Result data, zero when not driven |
| bus_oe | output | 1 | Bus drive enable |

## Verification
The bench builds the block with its default parameters: four channels, 14-bit words, a first-result latency of 17, a result step of 3 and a quiet window of 3. These values put the whole schedule within a few dozen clocks, so each result edge and the edge 28 and edge 29 acceptance boundary can be hit exactly from directed tasks. With four channels the pointer saturation is reached by the fifth read.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_CONV  = 2'd1,
      SQ_QUIET = 2'd2
   } seq_state_t;

   // width able to hold values 0..n
   function automatic int unsigned span_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/adc_seq_start_det.sv
module adc_seq_start_det (
   input  logic clk,
   input  logic rst_n,
   input  logic cnv_n,
   input  logic accept_win,
   output logic arm_pulse,
   output logic start_pulse
);
   logic cnv_q;
   logic armed;
   logic fall_seen;
   logic rise_seen;

   assign fall_seen   = cnv_q & ~cnv_n;
   assign rise_seen   = ~cnv_q & cnv_n;
   assign arm_pulse   = fall_seen & accept_win;
   assign start_pulse = rise_seen & armed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnv_q <= 1'b1;
         armed <= 1'b0;
      end else begin
         cnv_q <= cnv_n;
         if (start_pulse)
            armed <= 1'b0;
         else if (arm_pulse)
            armed <= 1'b1;
      end
   end
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
   import adc_seq_pkg::*;
#(
   parameter int unsigned NUM_CH    = 4,
   parameter int unsigned FIRST_LAT = 17,
   parameter int unsigned STEP      = 3,
   parameter int unsigned QUIET     = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_pulse,
   input  logic arm_pulse,
   output logic eoc_n,
   output logic eolc_n,
   output logic accept_win
);
   localparam int unsigned LAST_EDGE = FIRST_LAT + (NUM_CH - 1) * STEP;
   localparam int unsigned CNT_W     = span_w(LAST_EDGE + STEP);
   localparam int unsigned IDX_W     = span_w(NUM_CH);
   localparam int unsigned Q_W       = span_w(QUIET);

   seq_state_t        state;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  due;
   logic [IDX_W-1:0]  idx;
   logic [Q_W-1:0]    qcnt;
   logic [CNT_W-1:0]  cnt_nxt;
   logic              hit;
   logic              last_hit;
   logic              quiet_end;

   assign cnt_nxt    = cnt + CNT_W'(1);
   assign hit        = (state == SQ_CONV) && (cnt_nxt == due);
   assign last_hit   = hit && (idx == IDX_W'(NUM_CH - 1));
   assign quiet_end  = (state == SQ_QUIET) && (qcnt == Q_W'(QUIET - 1));
   assign accept_win = (state == SQ_IDLE) || quiet_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= SQ_IDLE;
         cnt    <= '0;
         due    <= CNT_W'(FIRST_LAT);
         idx    <= '0;
         qcnt   <= '0;
         eoc_n  <= 1'b1;
         eolc_n <= 1'b1;
      end else begin
         eoc_n <= 1'b1;
         if (arm_pulse)
            eolc_n <= 1'b1;
         unique case (state)
            SQ_IDLE: begin
               if (start_pulse) begin
                  state <= SQ_CONV;
                  cnt   <= '0;
                  due   <= CNT_W'(FIRST_LAT);
                  idx   <= '0;
               end
            end
            SQ_CONV: begin
               cnt <= cnt_nxt;
               if (hit) begin
                  eoc_n <= 1'b0;
                  due   <= due + CNT_W'(STEP);
                  idx   <= idx + IDX_W'(1);
               end
               if (last_hit) begin
                  eolc_n <= 1'b0;
                  state  <= SQ_QUIET;
                  qcnt   <= '0;
               end
            end
            SQ_QUIET: begin
               if (quiet_end)
                  state <= SQ_IDLE;
               else
                  qcnt <= qcnt + Q_W'(1);
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adc_seq_rdport.sv
module adc_seq_rdport #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned DATA_W = 14
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_pulse,
   input  logic [NUM_CH*DATA_W-1:0] smp_data,
   input  logic                     cs_n,
   input  logic                     rd_n,
   output logic [DATA_W-1:0]        bus_q,
   output logic                     bus_oe
);
   localparam int unsigned IDX_W = (NUM_CH < 2) ? 1 : $clog2(NUM_CH);

   logic [DATA_W-1:0] held   [NUM_CH];
   logic [DATA_W-1:0] masked [NUM_CH];
   logic [DATA_W-1:0] word;
   logic [IDX_W-1:0]  ptr;
   logic              act;
   logic              act_q;
   logic              step;

   assign act  = ~cs_n & ~rd_n;
   assign step = act_q & ~act;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)
            held[ch] <= '0;
         else if (start_pulse)
            held[ch] <= smp_data[ch*DATA_W +: DATA_W];
      end
      assign masked[ch] = (ptr == IDX_W'(ch)) ? held[ch] : '0;
   end

   always_comb begin
      word = '0;
      for (int ch = 0; ch < NUM_CH; ch++)
         word = word | masked[ch];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         ptr   <= '0;
      end else begin
         act_q <= act;
         if (start_pulse)
            ptr <= '0;
         else if (step && (ptr != IDX_W'(NUM_CH - 1)))
            ptr <= ptr + IDX_W'(1);
      end
   end

   assign bus_oe = act;
   assign bus_q  = act ? word : '0;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
   parameter int unsigned NUM_CH    = 4,
   parameter int unsigned DATA_W    = 14,
   parameter int unsigned FIRST_LAT = 17,
   parameter int unsigned STEP      = 3,
   parameter int unsigned QUIET     = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cnv_n,
   input  logic [NUM_CH*DATA_W-1:0] smp_data,
   input  logic                     cs_n,
   input  logic                     rd_n,
   output logic                     eoc_n,
   output logic                     eolc_n,
   output logic [DATA_W-1:0]        bus_q,
   output logic                     bus_oe
);
   if (NUM_CH < 2) begin : g_bad_ch
      $error("adc_seq_ctrl: NUM_CH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_w
      $error("adc_seq_ctrl: DATA_W must be positive");
   end
   if (STEP < 1 || FIRST_LAT < 1) begin : g_bad_sched
      $error("adc_seq_ctrl: FIRST_LAT and STEP must be positive");
   end
   if (QUIET < 1) begin : g_bad_quiet
      $error("adc_seq_ctrl: QUIET must be positive");
   end

   logic accept_win;
   logic arm_pulse;
   logic start_pulse;

   adc_seq_start_det u_start (
      .clk         (clk),
      .rst_n       (rst_n),
      .cnv_n       (cnv_n),
      .accept_win  (accept_win),
      .arm_pulse   (arm_pulse),
      .start_pulse (start_pulse)
   );

   adc_seq_timer #(
      .NUM_CH    (NUM_CH),
      .FIRST_LAT (FIRST_LAT),
      .STEP      (STEP),
      .QUIET     (QUIET)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_pulse (start_pulse),
      .arm_pulse   (arm_pulse),
      .eoc_n       (eoc_n),
      .eolc_n      (eolc_n),
      .accept_win  (accept_win)
   );

   adc_seq_rdport #(
      .NUM_CH (NUM_CH),
      .DATA_W (DATA_W)
   ) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_pulse (start_pulse),
      .smp_data    (smp_data),
      .cs_n        (cs_n),
      .rd_n        (rd_n),
      .bus_q       (bus_q),
      .bus_oe      (bus_oe)
   );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
   parameter int unsigned DATA_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              rd_n,
   input logic              eoc_n,
   input logic              eolc_n,
   input logic [DATA_W-1:0] bus_q,
   input logic              bus_oe,
   input logic              start_pulse
);
   a_r4_eoc_single: assert property (@(posedge clk) disable iff (!rst_n)
      !eoc_n |=> eoc_n);

   a_r5_eolc_with_eoc: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eolc_n) |-> !eoc_n);

   a_r6_bus_gate: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> (!cs_n && !rd_n));

   a_r6_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe |-> (bus_q == '0));

   a_r7_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !rd_n && $past(!cs_n && !rd_n) && !$past(start_pulse))
         |-> $stable(bus_q));

   a_r9_no_extra_eoc: assert property (@(posedge clk) disable iff (!rst_n)
      (!eolc_n && $past(!eolc_n)) |-> eoc_n);

   a_r1_start_no_eoc: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> eoc_n);
endmodule

bind adc_seq_ctrl adc_seq_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cs_n        (cs_n),
   .rd_n        (rd_n),
   .eoc_n       (eoc_n),
   .eolc_n      (eolc_n),
   .bus_q       (bus_q),
   .bus_oe      (bus_oe),
   .start_pulse (start_pulse)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
   localparam int NCH = 4;
   localparam int DW  = 14;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cnv_n = 1'b1;
   logic [NCH*DW-1:0] smp_data = '0;
   logic            cs_n = 1'b1;
   logic            rd_n = 1'b1;
   logic            eoc_n;
   logic            eolc_n;
   logic [DW-1:0]   bus_q;
   logic            bus_oe;

   int n_chk  = 0;
   int n_fail = 0;
   int pos    = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   adc_seq_ctrl uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnv_n    (cnv_n),
      .smp_data (smp_data),
      .cs_n     (cs_n),
      .rd_n     (rd_n),
      .eoc_n    (eoc_n),
      .eolc_n   (eolc_n),
      .bus_q    (bus_q),
      .bus_oe   (bus_oe)
   );

   function automatic logic [DW-1:0] sval(input int set, input int ch);
      return DW'(set * 32'h0551 + ch * 32'h0123 + 32'h0042);
   endfunction

   task automatic load_set(input int set);
      for (int c = 0; c < NCH; c++)
         smp_data[c*DW +: DW] = sval(set, c);
   endtask

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   endtask

   task automatic adv_to(input int k);
      repeat (k - pos) @(posedge clk);
      pos = k;
      @(negedge clk);
   endtask

   task automatic start_conv();
      @(negedge clk) cnv_n = 1'b0;
      @(negedge clk) cnv_n = 1'b1;
      @(posedge clk);
      pos = 0;
      @(negedge clk);
   endtask

   // one read cycle starting at the current negedge; consumes two edges
   task automatic do_read(input bit tie, input logic [DW-1:0] exp,
                          input string req);
      rd_n = 1'b0;
      if (tie) cs_n = 1'b0;
      #1;
      check({req, " oe"}, 32'(bus_oe), 32'd1);
      check({req, " data"}, 32'(bus_q), 32'(exp));
      @(negedge clk);
      rd_n = 1'b1;
      if (tie) cs_n = 1'b1;
      #1;
      check("R6 released oe", 32'(bus_oe), 32'd0);
      check("R6 released data", 32'(bus_q), 32'd0);
      @(negedge clk);
      pos = pos + 2;
   endtask

   task automatic t_reset();
      check("R5 reset eolc_n", 32'(eolc_n), 32'd1);
      check("R4 reset eoc_n", 32'(eoc_n), 32'd1);
      check("R6 reset oe", 32'(bus_oe), 32'd0);
      check("R6 reset data", 32'(bus_q), 32'd0);
   endtask

   task automatic t_schedule_and_reads();
      load_set(0);
      start_conv();
      load_set(9);                     // R1: ignored after capture
      adv_to(16); check("R2 eoc edge16", 32'(eoc_n), 32'd1);
      adv_to(17); check("R2 eoc edge17", 32'(eoc_n), 32'd0);
      adv_to(18); check("R4 eoc edge18", 32'(eoc_n), 32'd1);
      adv_to(20); check("R3 eoc edge20", 32'(eoc_n), 32'd0);
      adv_to(21); check("R4 eoc edge21", 32'(eoc_n), 32'd1);
      adv_to(23); check("R3 eoc edge23", 32'(eoc_n), 32'd0);
      adv_to(25); check("R5 eolc edge25", 32'(eolc_n), 32'd1);
      adv_to(26); check("R3 eoc edge26", 32'(eoc_n), 32'd0);
      check("R5 eolc edge26", 32'(eolc_n), 32'd0);
      adv_to(27); check("R4 eoc edge27", 32'(eoc_n), 32'd1);
      check("R5 eolc held", 32'(eolc_n), 32'd0);
      // R8: select held low for the whole sequence
      cs_n = 1'b0;
      for (int c = 0; c < NCH; c++)
         do_read(1'b0, sval(0, c), "R3 R1 R8 cs held read");
      do_read(1'b0, sval(0, NCH - 1), "R7 repeat last");
      do_read(1'b0, sval(0, NCH - 1), "R7 repeat last again");
      cs_n = 1'b1;
      check("R6 select high oe", 32'(bus_oe), 32'd0);
      adv_to(pos + 2); check("R5 eolc still low", 32'(eolc_n), 32'd0);
   endtask

   task automatic t_reads_during_conv();
      load_set(1);
      start_conv();
      load_set(2);
      adv_to(17); check("R2 second conv", 32'(eoc_n), 32'd0);
      do_read(1'b1, sval(1, 0), "R10 R8 tied read ch0");
      adv_to(20);
      do_read(1'b1, sval(1, 1), "R8 tied read ch1");
      adv_to(23);
      do_read(1'b1, sval(1, 2), "R8 tied read ch2");
      adv_to(26); check("R5 eolc tied", 32'(eolc_n), 32'd0);
      do_read(1'b1, sval(1, 3), "R8 tied read ch3");
      adv_to(35);
   endtask

   task automatic t_ignored_starts();
      load_set(3);
      start_conv();
      adv_to(10);
      load_set(4);
      cnv_n = 1'b0;                     // fall sampled at edge 11
      adv_to(11); cnv_n = 1'b1;
      adv_to(16); check("R9 mid-conv eoc16", 32'(eoc_n), 32'd1);
      adv_to(17); check("R9 mid-conv eoc17", 32'(eoc_n), 32'd0);
      do_read(1'b1, sval(3, 0), "R9 samples kept");
      adv_to(26); check("R5 eolc low", 32'(eolc_n), 32'd0);
      cnv_n = 1'b0;                     // fall at edge 27: in quiet window
      adv_to(27); cnv_n = 1'b1;
      adv_to(28); check("R9 quiet fall ignored", 32'(eolc_n), 32'd0);
      check("R9 no eoc in quiet", 32'(eoc_n), 32'd1);
      cnv_n = 1'b0;                     // fall at edge 29: accepted
      adv_to(29); check("R9 R5 edge29 accepted", 32'(eolc_n), 32'd1);
      cnv_n = 1'b1;                     // next edge is the new edge 0
      pos = -1;
      adv_to(16); check("R1 restart eoc16", 32'(eoc_n), 32'd1);
      adv_to(17); check("R1 restart eoc17", 32'(eoc_n), 32'd0);
      do_read(1'b1, sval(4, 0), "R1 R10 new capture ch0");
      adv_to(26); check("R5 restart eolc", 32'(eolc_n), 32'd0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_schedule_and_reads();
      t_reads_during_conv();
      t_ignored_starts();
      done = 1'b1;
      summary();
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
      end
   end
endmodule